// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface Emulator

This block is a synthesizable stand-in for a byte-wide parallel NOR flash device. The bus arrives on active-low chip-select, output-enable and write-enable strobes, with an address and an 8-bit data path split into input, output and output-enable. These pins are assumed to be already synchronous to the system clock. A small internal byte array holds the contents. A command sequencer watches the bus writes for unlock sequences and turns them into byte programs, three sizes of erase, and entry to or exit from a product-identification read mode.

Program and erase take a fixed number of clock cycles, set by parameters. While an operation runs, the array cannot be seen. A read instead returns a status byte. Bit 7 of that byte is the complement of the final value of bit 7, and bit 6 flips on every new read. Firmware written for a real part can poll this byte in the usual way. Software drivers and boot code can run against this model before silicon or a board exists.

Top module: `nce_flash_emu`

## Requirements
- R1: After reset every array byte reads 0xFF, dq_oe is low and no operation is in progress.
- R2: A read cycle exists only while ce_n and oe_n are low and we_n is high. dq_oe follows that condition one clock later. The output byte is captured at the first clock of the read cycle and held until the cycle ends.
- R3: A program has four writes: 0xAA to the low ADDR_W bits of 0x5555, 0x55 to those of 0x2AAA, 0xA0 to 0x5555, then the target address with the data. After PROG_CYC cycles the byte holds the old value ANDed with the data, so bits only ever go from 1 to 0.
- R4: A bus write is active while ce_n and we_n are both low. Its address is taken in the first cycle both are low. Its data is taken in the last cycle before either strobe rises.
- R5: The sequence AA/55, 0x80 to 0x5555, AA/55, then 0x30 to any address sets the aligned 2^SECT_W-byte sector holding that address to 0xFF after ERASE_CYC cycles. Other sectors keep their data.
- R6: The same erase prefix followed by 0x50 sets the aligned 2^BLK_W-byte block (sixteen sectors by default) to 0xFF. Other blocks keep their data.
- R7: The erase prefix followed by 0x10 written to 0x5555 sets every byte to 0xFF. A 0x10 written to any other address is a broken sequence.
- R8: A read that starts while an operation runs returns a status byte. Bits 5:0 are zero. Bit 7 is the complement of bit 7 of the programmed data, which makes it 0 for any erase.
- R9: Status bit 6 takes opposite values on successive reads while the operation runs. Once the operation ends, repeated reads return the same stored byte.
- R10: The unlock pair followed by 0x90 to 0x5555 enters identification mode. In this mode reads return MAKER_ID at even addresses and PART_ID at odd addresses. The unlock pair followed by 0xF0 to 0x5555 returns to array reads.
- R11: A write that does not match the next expected step of a sequence returns the sequencer to idle. The array is left unchanged and no operation starts.
- R12: Every bus write received while an operation runs is ignored, including a complete command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data driven into the device by the host |
| dq_o | output | 8 | Data driven by the device during a read |
| dq_oe | output | 1 | High while the device drives dq_o |

## Verification
A read result is due at the first falling clock edge after the rising edge that first sees the read condition. The scoreboard monitor compares only at that edge, because it pops an expected item exactly when dq_oe rises.

A bus write reaches the sequencer two rising edges after the strobe is released. The operation goes busy one edge later and stays busy for PROG_CYC or ERASE_CYC edges. The bench therefore reads status immediately after the final write and reads data only after the duration plus a margin, so neither check lands on the boundary cycle.

An ignored write is proven by reading the untouched byte after the operation would have finished. Toggle parity carries over between operations, so bit 6 is masked in single reads and checked as a difference between two successive raw reads.

// File: rtl/nce_pkg.sv
`timescale 1ns/1ps
// Shared types and command constants for the flash command interface emulator.
// Assumes addresses are at most 16 bits wide, so the key addresses truncate cleanly.
package nce_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_KEY1,
        S_KEY2,
        S_PROG,
        S_ERS0,
        S_ERS1,
        S_ERS2
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_SECT,
        OP_BLK,
        OP_CHIP
    } op_kind_t;

    localparam logic [7:0]  D_KEY1   = 8'hAA;
    localparam logic [7:0]  D_KEY2   = 8'h55;
    localparam logic [7:0]  D_PROG   = 8'hA0;
    localparam logic [7:0]  D_ERASE  = 8'h80;
    localparam logic [7:0]  D_ID_IN  = 8'h90;
    localparam logic [7:0]  D_ID_OUT = 8'hF0;
    localparam logic [7:0]  D_SECT   = 8'h30;
    localparam logic [7:0]  D_BLK    = 8'h50;
    localparam logic [7:0]  D_CHIP   = 8'h10;

    localparam logic [15:0] A_KEY1   = 16'h5555;
    localparam logic [15:0] A_KEY2   = 16'h2AAA;

endpackage

// File: rtl/nce_bus_capture.sv
`timescale 1ns/1ps
// Turns the strobe-style write bus into single-cycle write events.
// A write is active while ce_n and we_n are both low. The address is taken in the
// first active cycle and the data in the last active cycle. One clock after the
// write ends, a one-cycle wr_vld pulse presents the pair.
// Assumes the bus pins are already synchronous to clk.
module nce_bus_capture #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_i,
    output logic              wr_vld,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    logic              wr_act;
    logic              wr_act_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;

    assign wr_act = ~ce_n & ~we_n;

    // Track the strobe, latch the address on entry and the data while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            wr_act_q <= wr_act;
            if (wr_act && !wr_act_q) begin
                addr_q <= addr;
            end
            if (wr_act) begin
                data_q <= dq_i;
            end
        end
    end

    // Emit one write event when the active window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_vld  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_vld <= wr_act_q && !wr_act;
            if (wr_act_q && !wr_act) begin
                wr_addr <= addr_q;
                wr_data <= data_q;
            end
        end
    end

endmodule

// File: rtl/nce_cmd_fsm.sv
`timescale 1ns/1ps
// Command sequencer. It walks the unlock and command steps and issues a one-cycle
// start with the operation kind, address and data. It also holds the
// identification-mode flag. A write that does not fit the current step returns
// to idle. All writes are ignored while busy is high.
module nce_cmd_fsm
    import nce_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_vld,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              start,
    output op_kind_t          start_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [7:0]        start_data,
    output logic              id_mode,
    output seq_state_t        state
);

    localparam logic [ADDR_W-1:0] KEY1 = ADDR_W'(A_KEY1);
    localparam logic [ADDR_W-1:0] KEY2 = ADDR_W'(A_KEY2);

    logic at_key1;
    logic at_key2;

    assign at_key1 = (wr_addr == KEY1);
    assign at_key2 = (wr_addr == KEY2);

    // Advance the sequence on each accepted write and issue operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            id_mode    <= 1'b0;
            start      <= 1'b0;
            start_op   <= OP_PROG;
            start_addr <= '0;
            start_data <= '0;
        end else begin
            start <= 1'b0;
            if (wr_vld && !busy) begin
                state <= S_IDLE;
                case (state)
                    S_IDLE: begin
                        if (at_key1 && wr_data == D_KEY1) state <= S_KEY1;
                    end
                    S_KEY1: begin
                        if (at_key2 && wr_data == D_KEY2) state <= S_KEY2;
                    end
                    S_KEY2: begin
                        if (at_key1) begin
                            case (wr_data)
                                D_PROG:   state   <= S_PROG;
                                D_ERASE:  state   <= S_ERS0;
                                D_ID_IN:  id_mode <= 1'b1;
                                D_ID_OUT: id_mode <= 1'b0;
                                default:  state   <= S_IDLE;
                            endcase
                        end
                    end
                    S_PROG: begin
                        start      <= 1'b1;
                        start_op   <= OP_PROG;
                        start_addr <= wr_addr;
                        start_data <= wr_data;
                    end
                    S_ERS0: begin
                        if (at_key1 && wr_data == D_KEY1) state <= S_ERS1;
                    end
                    S_ERS1: begin
                        if (at_key2 && wr_data == D_KEY2) state <= S_ERS2;
                    end
                    S_ERS2: begin
                        start_addr <= wr_addr;
                        start_data <= 8'hFF;
                        if (wr_data == D_SECT) begin
                            start    <= 1'b1;
                            start_op <= OP_SECT;
                        end else if (wr_data == D_BLK) begin
                            start    <= 1'b1;
                            start_op <= OP_BLK;
                        end else if (wr_data == D_CHIP && at_key1) begin
                            start    <= 1'b1;
                            start_op <= OP_CHIP;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/nce_op_timer.sv
`timescale 1ns/1ps
// Operation timer. It latches the operation on start and holds busy for exactly
// PROG_CYC or ERASE_CYC clocks. In the last busy cycle it raises commit, so the
// array update and the fall of busy land on the same edge.
// Assumes both durations are at least 1.
module nce_op_timer
    import nce_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PROG_CYC  = 24,
    parameter int ERASE_CYC = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_kind_t          start_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    output logic              busy,
    output logic              commit,
    output op_kind_t          cur_op,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [7:0]        cur_data,
    output logic              stat_b7n
);

    localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] remain;

    assign commit   = busy && (remain == '0);
    assign stat_b7n = (cur_op == OP_PROG) ? ~cur_data[7] : 1'b0;

    // Load on start, count down while busy, release on the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain   <= '0;
            cur_op   <= OP_PROG;
            cur_addr <= '0;
            cur_data <= '0;
        end else if (start && !busy) begin
            busy     <= 1'b1;
            remain   <= (start_op == OP_PROG) ? CNT_W'(PROG_CYC - 1) : CNT_W'(ERASE_CYC - 1);
            cur_op   <= start_op;
            cur_addr <= start_addr;
            cur_data <= start_data;
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

endmodule

// File: rtl/nce_array.sv
`timescale 1ns/1ps
// Byte array with program (AND-merge) and aligned region erase.
// Regions are 2^SECT_W bytes for a sector and 2^BLK_W bytes for a block; a chip
// erase clears the whole array. Reset fills the array with 0xFF. Reads are
// combinational. Assumes SECT_W <= BLK_W <= ADDR_W.
module nce_array
    import nce_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int SECT_W = 5,
    parameter int BLK_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_kind_t          op,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Decide whether byte address a lies in the region an erase targets.
    function automatic logic region_hit(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] t,
                                        input op_kind_t k);
        case (k)
            OP_SECT: region_hit = ((a >> SECT_W) == (t >> SECT_W));
            OP_BLK:  region_hit = ((a >> BLK_W) == (t >> BLK_W));
            OP_CHIP: region_hit = 1'b1;
            default: region_hit = 1'b0;
        endcase
    endfunction

    assign rd_data = mem[rd_addr];

    // Apply reset fill, byte program or region erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (commit) begin
            if (op == OP_PROG) begin
                mem[op_addr] <= mem[op_addr] & op_data;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (region_hit(ADDR_W'(i), op_addr, op)) begin
                        mem[i] <= 8'hFF;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/nce_flash_emu.sv
`timescale 1ns/1ps
// Top of the flash command interface emulator. It ties together write capture,
// the command sequencer, the operation timer and the array. It also owns the
// read path: the output byte is captured at the first clock of each read cycle,
// and comes from the status byte, the ID codes or the array, in that priority.
// Assumes all bus pins are synchronous to clk.
module nce_flash_emu
    import nce_pkg::*;
#(
    parameter int         ADDR_W    = 10,
    parameter int         SECT_W    = 5,
    parameter int         BLK_W     = 9,
    parameter int         PROG_CYC  = 24,
    parameter int         ERASE_CYC = 48,
    parameter logic [7:0] MAKER_ID  = 8'h3E,
    parameter logic [7:0] PART_ID   = 8'hB4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_i,
    output logic [7:0]        dq_o,
    output logic              dq_oe
);

    logic              wr_vld;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              start;
    op_kind_t          start_op;
    logic [ADDR_W-1:0] start_addr;
    logic [7:0]        start_data;
    logic              id_mode;
    seq_state_t        seq_state;
    logic              op_busy;
    logic              commit;
    op_kind_t          cur_op;
    logic [ADDR_W-1:0] cur_addr;
    logic [7:0]        cur_data;
    logic              stat_b7n;
    logic [7:0]        arr_data;
    logic              rd_act;
    logic              rd_act_q;
    logic              toggle;
    logic              op_is_prog;
    logic              seq_idle;

    assign op_is_prog = (cur_op == OP_PROG);
    assign seq_idle   = (seq_state == S_IDLE);
    assign rd_act     = ~ce_n & ~oe_n & we_n;

    nce_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .dq_i    (dq_i),
        .wr_vld  (wr_vld),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    nce_cmd_fsm #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_vld     (wr_vld),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (op_busy),
        .start      (start),
        .start_op   (start_op),
        .start_addr (start_addr),
        .start_data (start_data),
        .id_mode    (id_mode),
        .state      (seq_state)
    );

    nce_op_timer #(
        .ADDR_W    (ADDR_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_op   (start_op),
        .start_addr (start_addr),
        .start_data (start_data),
        .busy       (op_busy),
        .commit     (commit),
        .cur_op     (cur_op),
        .cur_addr   (cur_addr),
        .cur_data   (cur_data),
        .stat_b7n   (stat_b7n)
    );

    nce_array #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .BLK_W  (BLK_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .op      (cur_op),
        .op_addr (cur_addr),
        .op_data (cur_data),
        .rd_addr (addr),
        .rd_data (arr_data)
    );

    // Capture the output byte at read start and flip the toggle bit on busy reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            dq_oe    <= 1'b0;
            dq_o     <= '0;
            toggle   <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
            dq_oe    <= rd_act;
            if (rd_act && !rd_act_q) begin
                if (op_busy) begin
                    dq_o   <= {stat_b7n, toggle, 6'b000000};
                    toggle <= ~toggle;
                end else if (id_mode) begin
                    dq_o <= addr[0] ? PART_ID : MAKER_ID;
                end else begin
                    dq_o <= arr_data;
                end
            end
        end
    end

endmodule

// File: rtl/nce_flash_chk.sv
`timescale 1ns/1ps
// Property checker for the flash command interface emulator, bound into the top.
// Assumes the bound signals keep their meaning: op_busy is the operation window,
// stat_b7n the expected status bit 7, and seq_idle the sequencer idle state.
module nce_flash_chk #(
    parameter int PROG_CYC  = 24,
    parameter int ERASE_CYC = 48
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic [7:0] dq_o,
    input logic       dq_oe,
    input logic       busy,
    input logic       stat_b7n,
    input logic       op_prog,
    input logic       seq_idle
);

    logic [31:0] busy_len;

    // Measure the length of each busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (busy) begin
            busy_len <= busy_len + 1;
        end else begin
            busy_len <= '0;
        end
    end

    // R2
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n) |=> dq_oe);

    // R2
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && !oe_n && we_n) |=> !dq_oe);

    // R8
    busy_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dq_oe) && $past(busy)) |-> (dq_o[5:0] == 6'd0 && dq_o[7] == $past(stat_b7n)));

    // R3
    op_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == (op_prog ? 32'(PROG_CYC) : 32'(ERASE_CYC))));

    // R12
    idle_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> seq_idle);

endmodule

bind nce_flash_emu nce_flash_chk #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe),
    .busy     (op_busy),
    .stat_b7n (stat_b7n),
    .op_prog  (op_is_prog),
    .seq_idle (seq_idle)
);

// File: tb/test_nce_flash_emu.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue the expected byte, and a monitor pops and
// compares it when dq_oe rises.
module test_nce_flash_emu;

    localparam int         AW    = 10;
    localparam int         PROG  = 24;
    localparam int         ERS   = 48;
    localparam logic [7:0] MAKER = 8'h3E;
    localparam logic [7:0] PART  = 8'hB4;
    localparam logic [AW-1:0] K1 = AW'(16'h5555);
    localparam logic [AW-1:0] K2 = AW'(16'h2AAA);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_i = '0;
    logic [7:0]    dq_o;
    logic          dq_oe;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      req;
        bit         chk;
    } item_t;

    item_t sb[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    oe_prev = 1'b0;
    bit    ended = 1'b0;

    always #2.5 clk = ~clk;

    nce_flash_emu i_nce_flash_emu (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .addr  (addr),
        .dq_i  (dq_i),
        .dq_o  (dq_o),
        .dq_oe (dq_oe)
    );

    task automatic score(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare each read result on the edge where dq_oe rises.
    always @(negedge clk) begin
        if (rst_n && dq_oe && !oe_prev) begin
            if (sb.size() == 0) begin
                score(1'b0, "R2 unexpected read", dq_o, 8'h00);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.chk) score((dq_o & it.mask) == (it.exp & it.mask), it.req, dq_o & it.mask, it.exp & it.mask);
            end
        end
        oe_prev = dq_oe;
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (2) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_exp(input logic [AW-1:0] a, input logic [7:0] e, input logic [7:0] m, input string req);
        item_t it;
        it.exp = e; it.mask = m; it.req = req; it.chk = 1'b1;
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        sb.push_back(it);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_raw(input logic [AW-1:0] a, output logic [7:0] v);
        item_t it;
        it.exp = 8'h00; it.mask = 8'h00; it.req = "raw"; it.chk = 1'b0;
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        sb.push_back(it);
        @(negedge clk);
        v = dq_o;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        bus_write(K1, 8'hAA);
        bus_write(K2, 8'h55);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d);
        unlock();
        bus_write(K1, 8'hA0);
        bus_write(a, d);
    endtask

    task automatic erase_cmd(input logic [AW-1:0] a, input logic [7:0] code);
        unlock();
        bus_write(K1, 8'h80);
        unlock();
        bus_write(a, code);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v1;
        logic [7:0] v2;
        repeat (4) @(negedge clk);
        score(dq_oe == 1'b0, "R1 dq_oe in reset", {7'd0, dq_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        score(dq_oe == 1'b0, "R1 dq_oe after reset", {7'd0, dq_oe}, 8'h00);
        read_exp(10'h000, 8'hFF, 8'hFF, "R1 erased byte low");
        read_exp(10'h3FF, 8'hFF, 8'hFF, "R1 erased byte high");

        // R2: chip deselected with oe low drives nothing.
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0;
        repeat (3) @(negedge clk);
        score(dq_oe == 1'b0, "R2 no drive when deselected", {7'd0, dq_oe}, 8'h00);
        oe_n = 1'b1;
        @(negedge clk);

        // R3 and R8: program, status read while busy, then the merged data.
        program_byte(10'h0A5, 8'h3C);
        read_exp(10'h0A5, 8'h80, 8'hBF, "R8 status bit7 complement");
        repeat (PROG + 4) @(negedge clk);
        read_exp(10'h0A5, 8'h3C, 8'hFF, "R3 programmed byte");
        program_byte(10'h0A5, 8'hF0);
        repeat (PROG + 4) @(negedge clk);
        read_exp(10'h0A5, 8'h30, 8'hFF, "R3 AND merge");

        // R9: toggle bit alternates while busy and stops afterwards.
        program_byte(10'h100, 8'h81);
        read_raw(10'h100, v1);
        read_raw(10'h100, v2);
        score(v1[6] != v2[6], "R9 toggle alternates", v2, ~v1);
        score(v1[7] == 1'b0 && v2[7] == 1'b0, "R8 status bit7 for data bit 1", {v1[7], v2[7], 6'd0}, 8'h00);
        repeat (PROG + 4) @(negedge clk);
        read_raw(10'h100, v1);
        read_raw(10'h100, v2);
        score(v1 == 8'h81 && v2 == 8'h81, "R9 toggle stopped", v2, 8'h81);

        // R4: address from the first active cycle, data from the last one.
        unlock();
        bus_write(K1, 8'hA0);
        @(negedge clk);
        addr = 10'h0C0; dq_i = 8'h99; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b0; addr = 10'h040;
        @(negedge clk);
        addr = 10'h0C0; dq_i = 8'h12;
        @(negedge clk);
        we_n = 1'b1; dq_i = 8'h77;
        @(negedge clk);
        ce_n = 1'b1;
        repeat (PROG + 6) @(negedge clk);
        read_exp(10'h040, 8'h12, 8'hFF, "R4 late address early data");
        read_exp(10'h0C0, 8'hFF, 8'hFF, "R4 stray address untouched");

        // R12: a full program issued while busy is dropped.
        program_byte(10'h041, 8'h00);
        program_byte(10'h042, 8'h00);
        repeat (PROG + 4) @(negedge clk);
        read_exp(10'h041, 8'h00, 8'hFF, "R12 first program done");
        read_exp(10'h042, 8'hFF, 8'hFF, "R12 busy write ignored");

        // R11: broken sequences leave the array untouched and start nothing.
        unlock();
        bus_write(K1, 8'h77);
        bus_write(10'h043, 8'h00);
        read_exp(10'h043, 8'hFF, 8'hFF, "R11 bad command byte");
        bus_write(K1, 8'hAA);
        bus_write(K2, 8'h12);
        bus_write(K1, 8'hA0);
        bus_write(10'h044, 8'h00);
        read_exp(10'h044, 8'hFF, 8'hFF, "R11 bad second key");

        // R5: sector erase clears only its own sector.
        program_byte(10'h0C0, 8'h55);
        repeat (PROG + 4) @(negedge clk);
        program_byte(10'h200, 8'h11);
        repeat (PROG + 4) @(negedge clk);
        program_byte(10'h3FF, 8'h0F);
        repeat (PROG + 4) @(negedge clk);
        erase_cmd(10'h0A7, 8'h30);
        read_exp(10'h0A5, 8'h00, 8'hBF, "R8 erase status");
        repeat (ERS + 4) @(negedge clk);
        read_exp(10'h0A5, 8'hFF, 8'hFF, "R5 sector cleared");
        read_exp(10'h0C0, 8'h55, 8'hFF, "R5 next sector kept");

        // R6: block erase clears the first block only.
        erase_cmd(10'h0C3, 8'h50);
        repeat (ERS + 4) @(negedge clk);
        read_exp(10'h0C0, 8'hFF, 8'hFF, "R6 block byte cleared");
        read_exp(10'h040, 8'hFF, 8'hFF, "R6 block byte cleared low");
        read_exp(10'h100, 8'hFF, 8'hFF, "R6 block byte cleared mid");
        read_exp(10'h200, 8'h11, 8'hFF, "R6 other block kept");

        // R10: identification mode entry and exit.
        unlock();
        bus_write(K1, 8'h90);
        read_exp(10'h000, MAKER, 8'hFF, "R10 maker code");
        read_exp(10'h201, PART, 8'hFF, "R10 part code");
        unlock();
        bus_write(K1, 8'hF0);
        read_exp(10'h200, 8'h11, 8'hFF, "R10 array after exit");

        // R7: chip erase needs the key address; a wrong address is ignored.
        erase_cmd(10'h123, 8'h10);
        repeat (ERS + 4) @(negedge clk);
        read_exp(10'h200, 8'h11, 8'hFF, "R11 chip code at wrong address");
        erase_cmd(K1, 8'h10);
        repeat (ERS + 4) @(negedge clk);
        read_exp(10'h200, 8'hFF, 8'hFF, "R7 chip erase");
        read_exp(10'h3FF, 8'hFF, 8'hFF, "R7 chip erase top");

        repeat (4) @(negedge clk);
        score(sb.size() == 0, "R2 all reads answered", 8'(sb.size()), 8'h00);
        finish_run();
    end

endmodule